// File: doc/BRIEF.md
# Bit-serial CORDIC engine

This block computes a CORDIC conversion with one-bit arithmetic. The three input words (abscissa, ordinate, angle) are captured together into three shift registers when the load strobe is sampled. Each micro-rotation then takes one pass of W clocks. In every clock the register contents move one place toward the LSB. The LSB of each register goes into a one-bit adder/subtractor whose carry is kept in a flip-flop, and the new bit enters at the MSB.

Two operands are produced without any barrel shifter. The other coordinate, shifted by the iteration index, is read from a fixed tap of its shift register, and the bits beyond its MSB are filled with its latched sign. The arctangent constant is delivered one bit per clock from a table that is computed at elaboration.

A parameter fixes the mode for the whole instance:
- **Rotation:** the vector is turned by the angle input.
- **Vectoring:** the vector is turned onto the positive x axis and the angle used is accumulated.

The results carry the usual CORDIC gain, and nothing in the block compensates for it. A system typically uses the engine to fill a sine/cosine table at power-up. It then drops the clock enable to park the engine.

Top module: `cordic_serial`

## Requirements
- R1: While `rst` is high at a rising edge, the engine goes idle: `ready` is 0 and `x_out`, `y_out` and `a_out` are 0 from the following cycle. Any conversion in progress is abandoned and no `ready` pulse follows it.
- R2: In rotation mode, each of the N iterations is computed on W-bit two's-complement words that wrap on overflow, with i counting 0 to N-1 and the shifts arithmetic.
  - The direction is positive when `a` is at least 0.
  - With a positive direction: x' = x - (y>>>i), y' = y + (x>>>i), a' = a - C(i).
  - With a negative direction, all three signs are flipped.
  - The published outputs are the final x, y and a.
- R3: In vectoring mode the same recurrence is used, but the direction is positive only when `y` is negative.
- R4: A conversion occupies W*N+2 enabled cycles. The load edge starts the first of them. `ready` is high in the last of them, which begins on the (W*N+1)-th enabled edge after the load edge.
- R5: `ready` is high for exactly one enabled cycle per completed conversion.
- R6: A load strobe sampled while a conversion runs restarts the engine with the new inputs. The abandoned conversion never raises `ready`.
- R7: A load strobe may be given in the same cycle as `ready`. The new conversion then starts at that edge, with the same timing as a load from idle.
- R8: When `en` is low at a rising edge, every register holds, so the outputs and `ready` do not change. A conversion is lengthened by exactly the number of stalled edges.
- R9: The angle code uses 2^(W-1) for pi radians, and linear values use 2^(W-2) for 1.0. The constant is C(i) = round(atan(2^-i) * 2^(W-1) / pi).
- R10: When the shift index reaches or exceeds the remaining width, the shifted operand is made up entirely of copies of its sign bit. This also covers N greater than W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; low freezes all state |
| ld | input | 1 | Load strobe: capture inputs and start a conversion |
| x_in | input | W | Initial abscissa (magnitude in rotation mode) |
| y_in | input | W | Initial ordinate |
| a_in | input | W | Initial angle (rotation mode) or zero (vectoring) |
| x_out | output | W | Final abscissa, or scaled magnitude in vectoring mode |
| y_out | output | W | Final ordinate |
| a_out | output | W | Final angle accumulator |
| ready | output | 1 | One-cycle pulse marking valid results |

## Verification
A wrong direction latch, a carry seeded with the wrong value, or a tap read from the wrong position corrupts the first iteration it touches. That error then spreads through every later iteration. It therefore shows up on the output words as a mismatch in the single `ready` cycle of that conversion, which is W*N+1 enabled edges after the load.

A counter that is off by one, or a sequencer that skips its final cycle, does not corrupt the data. Instead it moves or repeats the `ready` pulse, and this is visible at the exact cycle where the pulse was due.

Enable stalls and restarts are run against a model that only counts enabled edges. A register that ignores `en` therefore drifts out of step within a single conversion.

// File: rtl/cordic_bs_pkg.sv
package cordic_bs_pkg;

    typedef enum logic {
        MODE_ROTATE = 1'b0,
        MODE_VECTOR = 1'b1
    } cordic_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    localparam real CB_PI = 3.14159265358979323846;

    // One-bit full adder used by every serial lane.
    function automatic fa_out_t serial_fa(input logic a, input logic b, input logic c);
        fa_out_t r;
        r.sum   = a ^ b ^ c;
        r.carry = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

    // atan(2^-idx) scaled so that pi maps to 2^(width-1), rounded to nearest.
    function automatic logic [63:0] atan_code(input int idx, input int width);
        real t;
        real acc;
        real term;
        real scale;
        t = 1.0;
        for (int k = 0; k < idx; k++) t = t / 2.0;
        if (idx == 0) begin
            acc = CB_PI / 4.0;
        end else begin
            acc  = 0.0;
            term = t;
            for (int n = 0; n < 40; n++) begin
                if (n % 2 == 0) acc = acc + term / real'(2 * n + 1);
                else            acc = acc - term / real'(2 * n + 1);
                term = term * t * t;
            end
        end
        scale = 1.0;
        for (int k = 0; k < width - 1; k++) scale = scale * 2.0;
        return 64'(longint'(acc / CB_PI * scale));
    endfunction

endpackage

// File: rtl/cbs_lane.sv
module cbs_lane
    import cordic_bs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic         step,
    input  logic         first,
    input  logic         opnd,
    input  logic         sub,
    input  logic [W-1:0] init,
    output logic [W-1:0] word
);
    logic    carry_q;
    logic    cin;
    fa_out_t fa;

    // Subtraction = add inverted operand with carry seeded to 1 on bit 0.
    always_comb begin
        cin = first ? sub : carry_q;
        fa  = serial_fa(word[0], opnd ^ sub, cin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word    <= '0;
            carry_q <= 1'b0;
        end else if (en) begin
            if (load) begin
                word    <= init;
                carry_q <= 1'b0;
            end else if (step) begin
                word    <= {fa.sum, word[W-1:1]};
                carry_q <= fa.carry;
            end
        end
    end
endmodule

// File: rtl/cbs_tap.sv
module cbs_tap #(
    parameter int W  = 16,
    parameter int N  = 16,
    parameter int IW = 4,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          step,
    input  logic          first,
    input  logic [W-1:0]  word,
    input  logic [IW-1:0] it_cnt,
    input  logic [BW-1:0] bit_cnt,
    output logic          tap
);
    localparam int unsigned WM1 = W - 1;

    logic           sign_q;
    logic           sign_now;
    logic [W+N-1:0] ext;

    // After k shifts, original bit k+i sits at position i until it would
    // come from beyond the MSB; from then on the latched sign is used.
    always_comb begin
        sign_now = first ? word[W-1] : sign_q;
        ext      = {{N{sign_now}}, word};
        if (32'(bit_cnt) + 32'(it_cnt) <= WM1) tap = ext[it_cnt];
        else                                   tap = sign_now;
    end

    always_ff @(posedge clk) begin
        if (rst)                         sign_q <= 1'b0;
        else if (en && step && first)    sign_q <= word[W-1];
    end
endmodule

// File: rtl/cbs_atan_rom.sv
module cbs_atan_rom
    import cordic_bs_pkg::*;
#(
    parameter int W  = 16,
    parameter int N  = 16,
    parameter int IW = 4,
    parameter int BW = 4
) (
    input  logic [IW-1:0] it_cnt,
    input  logic [BW-1:0] bit_cnt,
    output logic          bit_o
);
    logic [W-1:0] lut_w [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        localparam logic [63:0] CODE = atan_code(g, W);
        assign lut_w[g] = CODE[W-1:0];
    end

    assign bit_o = lut_w[it_cnt][bit_cnt];
endmodule

// File: rtl/cbs_seq.sv
module cbs_seq
    import cordic_bs_pkg::*;
#(
    parameter int W  = 16,
    parameter int N  = 16,
    parameter int IW = 4,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          load,
    output logic          step,
    output logic          first,
    output logic [IW-1:0] it_cnt,
    output logic [BW-1:0] bit_cnt,
    output logic          ready
);
    seq_state_e st;

    assign step  = (st == SQ_RUN);
    assign first = (bit_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            bit_cnt <= '0;
            it_cnt  <= '0;
            ready   <= 1'b0;
        end else if (en) begin
            if (load) begin
                st      <= SQ_RUN;
                bit_cnt <= '0;
                it_cnt  <= '0;
                ready   <= 1'b0;
            end else begin
                case (st)
                    SQ_RUN: begin
                        if (bit_cnt == BW'(W - 1)) begin
                            bit_cnt <= '0;
                            if (it_cnt == IW'(N - 1)) begin
                                it_cnt <= '0;
                                st     <= SQ_DRAIN;
                            end else begin
                                it_cnt <= it_cnt + IW'(1);
                            end
                        end else begin
                            bit_cnt <= bit_cnt + BW'(1);
                        end
                    end
                    SQ_DRAIN: begin
                        ready <= 1'b1;
                        st    <= SQ_IDLE;
                    end
                    default: begin
                        ready <= 1'b0;
                        st    <= SQ_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cordic_serial.sv
module cordic_serial
    import cordic_bs_pkg::*;
#(
    parameter int           W    = 16,
    parameter int           N    = 16,
    parameter cordic_mode_e MODE = MODE_ROTATE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] x_out,
    output logic [W-1:0] y_out,
    output logic [W-1:0] a_out,
    output logic         ready
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic          step;
    logic          first;
    logic [IW-1:0] it_cnt;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  x_w;
    logic [W-1:0]  y_w;
    logic [W-1:0]  a_w;
    logic          tap_x;
    logic          tap_y;
    logic          rom_bit;
    logic          d_raw;
    logic          d_q;
    logic          d_now;

    cbs_seq #(.W(W), .N(N), .IW(IW), .BW(BW)) u_seq (
        .clk(clk), .rst(rst), .en(en), .load(ld),
        .step(step), .first(first), .it_cnt(it_cnt), .bit_cnt(bit_cnt), .ready(ready)
    );

    // Direction source depends on the mode: positive means x subtracts.
    if (MODE == MODE_ROTATE) begin : g_rot
        assign d_raw = ~a_w[W-1];
    end else begin : g_vec
        assign d_raw = y_w[W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)                      d_q <= 1'b0;
        else if (en && step && first) d_q <= d_raw;
    end

    assign d_now = first ? d_raw : d_q;

    cbs_tap #(.W(W), .N(N), .IW(IW), .BW(BW)) u_tap_x (
        .clk(clk), .rst(rst), .en(en), .step(step), .first(first),
        .word(x_w), .it_cnt(it_cnt), .bit_cnt(bit_cnt), .tap(tap_x)
    );

    cbs_tap #(.W(W), .N(N), .IW(IW), .BW(BW)) u_tap_y (
        .clk(clk), .rst(rst), .en(en), .step(step), .first(first),
        .word(y_w), .it_cnt(it_cnt), .bit_cnt(bit_cnt), .tap(tap_y)
    );

    cbs_atan_rom #(.W(W), .N(N), .IW(IW), .BW(BW)) u_rom (
        .it_cnt(it_cnt), .bit_cnt(bit_cnt), .bit_o(rom_bit)
    );

    cbs_lane #(.W(W)) u_lane_x (
        .clk(clk), .rst(rst), .en(en), .load(ld), .step(step), .first(first),
        .opnd(tap_y), .sub(d_now), .init(x_in), .word(x_w)
    );

    cbs_lane #(.W(W)) u_lane_y (
        .clk(clk), .rst(rst), .en(en), .load(ld), .step(step), .first(first),
        .opnd(tap_x), .sub(~d_now), .init(y_in), .word(y_w)
    );

    cbs_lane #(.W(W)) u_lane_a (
        .clk(clk), .rst(rst), .en(en), .load(ld), .step(step), .first(first),
        .opnd(rom_bit), .sub(d_now), .init(a_in), .word(a_w)
    );

    assign x_out = x_w;
    assign y_out = y_w;
    assign a_out = a_w;
endmodule

// File: rtl/cordic_serial_chk.sv
module cordic_serial_chk #(
    parameter int W = 16,
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         ld,
    input logic         ready,
    input logic [W-1:0] x_out,
    input logic [W-1:0] y_out,
    input logic [W-1:0] a_out
);
    localparam int unsigned LAT = W * N + 1;

    logic        armed;
    int unsigned span;

    // Enabled edges since the last accepted load.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            span  <= 0;
        end else if (en) begin
            if (ld) begin
                armed <= 1'b1;
                span  <= 0;
            end else if (ready) begin
                armed <= 1'b0;
            end else if (armed && span <= LAT) begin
                span <= span + 1;
            end
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!ready && x_out == '0 && y_out == '0 && a_out == '0));

    p_ready_latency_r4: assert property (@(posedge clk) disable iff (rst)
        ready |-> (armed && span == LAT));

    p_ready_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (ready && en) |=> !ready);

    p_load_restarts_r6: assert property (@(posedge clk) disable iff (rst)
        (ld && en) |=> !ready);

    p_stall_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(x_out) && $stable(y_out) && $stable(a_out) && $stable(ready)));
endmodule

bind cordic_serial cordic_serial_chk #(.W(W), .N(N)) u_chk (
    .clk(clk), .rst(rst), .en(en), .ld(ld), .ready(ready),
    .x_out(x_out), .y_out(y_out), .a_out(a_out)
);

// File: tb/tb_cordic_serial.sv
module tb_cordic_serial;
    import cordic_bs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W0 = 16;
    localparam int N0 = 16;
    localparam int W1 = 12;
    localparam int N1 = 14;
    localparam longint L0 = W0 * N0 + 1;
    localparam longint L1 = W1 * N1 + 1;
    localparam longint M0 = (longint'(1) <<< W0) - 1;
    localparam longint M1 = (longint'(1) <<< W1) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic ld  = 1'b0;
    logic [W0-1:0] x0_i = '0, y0_i = '0, a0_i = '0;
    logic [W0-1:0] x0_o, y0_o, a0_o;
    logic          rdy0;
    logic [W1-1:0] x1_i = '0, y1_i = '0, a1_i = '0;
    logic [W1-1:0] x1_o, y1_o, a1_o;
    logic          rdy1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cordic_serial #(.W(W0), .N(N0), .MODE(MODE_ROTATE)) dut (
        .clk(clk), .rst(rst), .en(en), .ld(ld),
        .x_in(x0_i), .y_in(y0_i), .a_in(a0_i),
        .x_out(x0_o), .y_out(y0_o), .a_out(a0_o), .ready(rdy0)
    );

    cordic_serial #(.W(W1), .N(N1), .MODE(MODE_VECTOR)) dut_vec (
        .clk(clk), .rst(rst), .en(en), .ld(ld),
        .x_in(x1_i), .y_in(y1_i), .a_in(a1_i),
        .x_out(x1_o), .y_out(y1_o), .a_out(a1_o), .ready(rdy1)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R4";

    longint m_cnt [2] = '{0, 0};
    bit     m_busy[2] = '{0, 0};
    longint ex[2] = '{0, 0};
    longint ey[2] = '{0, 0};
    longint ea[2] = '{0, 0};

    // Stimulus sets: rotation (x, y, a) for dut, vectoring (x, y) for dut_vec.
    longint rx[6] = '{9830, 9830, 12000, 6000, 16384, -8000};
    longint ry[6] = '{0, 0, 0, -7000, 0, 3000};
    longint ra[6] = '{8192, -10923, 0, -4000, 16000, -16384};
    longint vx[6] = '{600, 900, -500, 0, 1000, -800};
    longint vy[6] = '{-600, 200, 300, 1000, 0, -100};

    task automatic chk(input string tag, input longint act, input longint want);
        n_chk++;
        if (act != want) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, want);
        end
    endtask

    function automatic longint sext(input longint v, input int w);
        longint r;
        r = v & ((longint'(1) <<< w) - 1);
        if (r[w-1]) r = r - (longint'(1) <<< w);
        return r;
    endfunction

    function automatic longint angle_const(input int i, input int w);
        real t;
        real s;
        t = 1.0;
        for (int k = 0; k < i; k++) t = t / 2.0;
        s = 1.0;
        for (int k = 0; k < w - 1; k++) s = s * 2.0;
        return longint'($atan(t) / $acos(-1.0) * s);
    endfunction

    task automatic ref_conv(input int w, input int n, input bit vec,
                            input longint xi, input longint yi, input longint ai,
                            output longint xo, output longint yo, output longint ao);
        longint x, y, a, xn, yn;
        bit pos;
        x = sext(xi, w);
        y = sext(yi, w);
        a = sext(ai, w);
        for (int i = 0; i < n; i++) begin
            pos = vec ? (y < 0) : (a >= 0);
            if (pos) begin
                xn = x - (y >>> i);
                yn = y + (x >>> i);
                a  = sext(a - angle_const(i, w), w);
            end else begin
                xn = x + (y >>> i);
                yn = y - (x >>> i);
                a  = sext(a + angle_const(i, w), w);
            end
            x = sext(xn, w);
            y = sext(yn, w);
        end
        xo = x;
        yo = y;
        ao = a;
    endtask

    function automatic bit exp_rdy(input int d);
        return m_busy[d] && (m_cnt[d] == ((d == 0) ? L0 : L1));
    endfunction

    // Behavioural model: counts enabled edges since the load.
    always @(posedge clk) begin
        if (rst) begin
            m_busy[0] = 1'b0;
            m_busy[1] = 1'b0;
        end else if (en) begin
            if (ld) begin
                m_busy[0] = 1'b1;
                m_cnt[0]  = 0;
                m_busy[1] = 1'b1;
                m_cnt[1]  = 0;
                ref_conv(W0, N0, 1'b0, longint'(x0_i), longint'(y0_i), longint'(a0_i),
                         ex[0], ey[0], ea[0]);
                ref_conv(W1, N1, 1'b1, longint'(x1_i), longint'(y1_i), longint'(a1_i),
                         ex[1], ey[1], ea[1]);
            end else begin
                for (int d = 0; d < 2; d++) begin
                    if (m_busy[d]) begin
                        if (m_cnt[d] == ((d == 0) ? L0 : L1)) m_busy[d] = 1'b0;
                        else                                   m_cnt[d]++;
                    end
                end
            end
        end
    end

    task automatic tick();
        bit r0 = exp_rdy(0);
        bit r1 = exp_rdy(1);
        bit e  = en;
        @(negedge clk);
        if (r0 && e) chk("R5 pulse width dut", longint'(rdy0), 0);
        if (r1 && e) chk("R5 pulse width dut_vec", longint'(rdy1), 0);
        chk({cur_req, " ready dut"}, longint'(rdy0), longint'(exp_rdy(0)));
        chk({cur_req, " ready dut_vec"}, longint'(rdy1), longint'(exp_rdy(1)));
        if (exp_rdy(0)) begin
            chk("R2 x rotation", longint'(x0_o), ex[0] & M0);
            chk("R2 y rotation", longint'(y0_o), ey[0] & M0);
            chk("R2/R9 angle rotation", longint'(a0_o), ea[0] & M0);
        end
        if (exp_rdy(1)) begin
            chk("R3/R10 x vectoring", longint'(x1_o), ex[1] & M1);
            chk("R3/R10 y vectoring", longint'(y1_o), ey[1] & M1);
            chk("R3/R9 angle vectoring", longint'(a1_o), ea[1] & M1);
        end
    endtask

    task automatic set_inputs(input int k);
        x0_i = W0'(rx[k]);
        y0_i = W0'(ry[k]);
        a0_i = W0'(ra[k]);
        x1_i = W1'(vx[k]);
        y1_i = W1'(vy[k]);
        a1_i = '0;
    endtask

    task automatic pulse_load(input int k);
        set_inputs(k);
        ld = 1'b1;
        tick();
        ld = 1'b0;
    endtask

    task automatic drain();
        for (int g = 0; g < 2000 && (m_busy[0] || m_busy[1]); g++) tick();
    endtask

    task automatic check_cleared();
        chk("R1 ready dut", longint'(rdy0), 0);
        chk("R1 x dut", longint'(x0_o), 0);
        chk("R1 y dut", longint'(y0_o), 0);
        chk("R1 a dut", longint'(a0_o), 0);
        chk("R1 ready dut_vec", longint'(rdy1), 0);
        chk("R1 x dut_vec", longint'(x1_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c;
        bit held;
        logic [W0-1:0] snap;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        cur_req = "R1";
        check_cleared();

        // Plain conversions in both modes (R2, R3, R4, R9, R10).
        cur_req = "R4";
        for (int k = 0; k < 6; k++) begin
            pulse_load(k);
            drain();
        end

        // Restart mid-conversion (R6).
        cur_req = "R6";
        pulse_load(0);
        repeat (40) tick();
        pulse_load(3);
        drain();

        // Load coinciding with ready (R7).
        cur_req = "R7";
        pulse_load(1);
        for (int g = 0; g < 1000 && !exp_rdy(0); g++) tick();
        chk("R7 ready present before reload", longint'(rdy0), 1);
        pulse_load(4);
        drain();

        // Enable stalls (R8).
        cur_req = "R8";
        pulse_load(2);
        c = 0;
        held = 1'b0;
        for (int g = 0; g < 3000 && (m_busy[0] || m_busy[1]); g++) begin
            if (exp_rdy(0) && !held) begin
                snap = x0_o;
                en = 1'b0;
                repeat (4) tick();
                chk("R8 x held while stalled", longint'(x0_o), longint'(snap));
                chk("R8 ready held while stalled", longint'(rdy0), 1);
                en = 1'b1;
                held = 1'b1;
                tick();
            end else begin
                en = (c % 3 != 0);
                c++;
                tick();
            end
        end
        en = 1'b1;
        tick();

        // Synchronous reset abandons a conversion (R1).
        cur_req = "R1";
        pulse_load(5);
        repeat (30) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check_cleared();
        repeat (300) tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule